// File: doc/BRIEF.md
# UART Receiver with Break Lockout

This block is the receive half of an asynchronous serial port. It watches a serial line through a two-stage synchronizer and counts the ticks of an oversampling baud strobe, 16 ticks per bit by default. A falling edge starts a character. The edge is confirmed only if the line is still low at mid-bit. The block then samples the data bits least-significant first, an optional parity bit and one stop bit, each at the centre of its bit. Every finished character goes into a small receive queue as one tagged word. The word holds the byte and four flags that travel with that character: frame error, parity error, break and overrun.

A line held low through every sample slot of a whole frame is a break. A break puts exactly one zero character with the break flag into the queue. The receiver then accepts nothing until the line has been seen high and a new, confirmed start bit follows.

Software or a downstream block drains the queue through a valid/ready read port. `rd_valid` is high while the queue holds a word, and `rd_data` shows the head word. A cycle with both `rd_valid` and `rd_ready` high removes the head word. The receive side cannot be stalled. When the queue is full, a new character is dropped, and the overrun flag of the newest stored word records the loss. `rx_irq` stays high as long as the head word carries a frame, parity or break flag.

Top module: `uart_rx_break_top`

## Requirements
- R1: The read word holds the received byte in bits 7:0, least-significant bit first on the line, the frame error in bit 8, the parity error in bit 9, the break flag in bit 10 and the overrun flag in bit 11.
- R2: A falling edge on the synchronized line starts a character only if the line is still low at the eighth tick (mid-bit). A low pulse shorter than that produces no word.
- R3: A character whose stop bit is sampled low gets bit 8 set. A new start is then recognized only after the line has gone high and fallen again.
- R4: With parity enabled, `par_odd`=0 selects even parity and `par_odd`=1 selects odd parity. The count is taken over the data and parity bits. Bit 9 is set when the received parity bit disagrees with that rule.
- R5: With `par_en`=0 there is no parity slot: the stop bit follows the last data bit directly, and bit 9 is always 0.
- R6: A frame is a break when the start, data, parity (if enabled) and stop samples are all low. A break stores exactly one word 0x400: data zero, break flag set, frame and parity flags clear. Holding the line low longer stores nothing more.
- R7: After a break no word is stored until the synchronized line has been high and a new confirmed start bit has arrived.
- R8: The queue holds 16 words, returns them in arrival order, and each word keeps its own flags.
- R9: A character that completes while the queue is full, with no pop in the same cycle, is discarded, and bit 11 of the newest stored word is set.
- R10: A pop happens in a cycle where `rd_valid` and `rd_ready` are both high. While the queue is empty, `rd_ready` has no effect and `rd_data` keeps the last word popped.
- R11: `rx_irq` is high exactly when `rd_valid` is high and the head word has bit 8, 9 or 10 set.
- R12: After reset `rd_valid` and `rx_irq` are 0, `fifo_empty` is 1 and `rd_data` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| baud_tick | input | 1 | One-cycle oversampling strobe, OSR per bit |
| rx_line | input | 1 | Asynchronous serial input, idle high |
| par_en | input | 1 | Parity slot present when 1 |
| par_odd | input | 1 | 1 selects odd parity, 0 even |
| rd_ready | input | 1 | Consumer accepts the head word |
| rd_valid | output | 1 | Head word available |
| rd_data | output | DATA_W+4 | Head word (last popped word when empty) |
| fifo_empty | output | 1 | Queue holds no word |
| rx_irq | output | 1 | Head word carries an error flag |

## Verification
The bench builds the block with its defaults: 8 data bits, 16 ticks per bit and a 16-word queue. It issues a baud tick every second clock, so one bit lasts 32 clocks. A queue that shallow fills after a burst of 18 unread characters, which brings the overrun tagging of the newest word within reach. With a mid-bit point of 8 ticks, a 4-tick glitch tests start rejection. Random parity modes, corrupted parity and stop bits, and zero bytes with a low stop bit also produce breaks in the random mix, next to directed long breaks that test the lockout.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

  // Flag offsets above the data field of a stored word
  localparam int FLAG_FE = 0;
  localparam int FLAG_PE = 1;
  localparam int FLAG_BE = 2;
  localparam int FLAG_OE = 3;
  localparam int FLAG_N  = 4;

  typedef enum logic [2:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_PAR,
    RX_STOP,
    RX_LOCK
  } rx_state_e;

endpackage

// File: rtl/uart_rx_sync.sv
module uart_rx_sync #(
  parameter int STAGES    = 2,
  parameter bit RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_in,
  output logic d_out
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= {STAGES{RESET_VAL}};
    else        chain_q <= {chain_q[STAGES-2:0], d_in};
  end

  assign d_out = chain_q[STAGES-1];

endmodule

// File: rtl/uart_rx_engine.sv
module uart_rx_engine
  import uart_rx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OSR    = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     baud_tick,
  input  logic                     line_s,
  input  logic                     par_en,
  input  logic                     par_odd,
  output logic                     push_vld,
  output logic [DATA_W+FLAG_N-1:0] push_word
);

  localparam int CNT_W = (OSR > 1) ? $clog2(OSR) : 1;
  localparam int IDX_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam int HALF  = OSR / 2;

  rx_state_e         st_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [IDX_W-1:0]  bidx_q;
  logic [DATA_W-1:0] shreg_q;
  logic              all_low_q;
  logic              par_bit_q;
  logic              line_prev_q;

  logic half_hit, full_hit, exp_par, par_bad;

  assign half_hit = baud_tick && (cnt_q == CNT_W'(HALF - 1));
  assign full_hit = baud_tick && (cnt_q == CNT_W'(OSR - 1));
  assign exp_par  = (^shreg_q) ^ par_odd;
  assign par_bad  = par_en && (par_bit_q != exp_par);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q        <= RX_IDLE;
      cnt_q       <= '0;
      bidx_q      <= '0;
      shreg_q     <= '0;
      all_low_q   <= 1'b0;
      par_bit_q   <= 1'b0;
      line_prev_q <= 1'b1;
      push_vld    <= 1'b0;
      push_word   <= '0;
    end else begin
      push_vld    <= 1'b0;
      line_prev_q <= line_s;
      case (st_q)
        RX_IDLE: begin
          if (line_prev_q && !line_s) begin
            st_q      <= RX_START;
            cnt_q     <= '0;
            bidx_q    <= '0;
            all_low_q <= 1'b1;
          end
        end
        RX_START: begin
          if (half_hit) begin
            cnt_q <= '0;
            st_q  <= line_s ? RX_IDLE : RX_DATA;
          end else if (baud_tick) begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        RX_DATA: begin
          if (full_hit) begin
            cnt_q     <= '0;
            shreg_q   <= {line_s, shreg_q[DATA_W-1:1]};
            all_low_q <= all_low_q & ~line_s;
            if (bidx_q == IDX_W'(DATA_W - 1)) st_q <= par_en ? RX_PAR : RX_STOP;
            else                              bidx_q <= bidx_q + 1'b1;
          end else if (baud_tick) begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        RX_PAR: begin
          if (full_hit) begin
            cnt_q     <= '0;
            par_bit_q <= line_s;
            all_low_q <= all_low_q & ~line_s;
            st_q      <= RX_STOP;
          end else if (baud_tick) begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        RX_STOP: begin
          if (full_hit) begin
            cnt_q     <= '0;
            push_vld  <= 1'b1;
            push_word <= '0;
            if (all_low_q && !line_s) begin
              push_word[DATA_W+FLAG_BE] <= 1'b1;
              st_q                      <= RX_LOCK;
            end else begin
              push_word[DATA_W-1:0]     <= shreg_q;
              push_word[DATA_W+FLAG_FE] <= ~line_s;
              push_word[DATA_W+FLAG_PE] <= par_bad;
              st_q                      <= RX_IDLE;
            end
          end else if (baud_tick) begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        RX_LOCK: begin
          if (line_s) st_q <= RX_IDLE;
        end
        default: st_q <= RX_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/uart_rx_tag_fifo.sv
module uart_rx_tag_fifo #(
  parameter int W       = 12,
  parameter int DEPTH   = 16,
  parameter int OVR_BIT = 11
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push_vld,
  input  logic [W-1:0] push_word,
  input  logic         pop_req,
  output logic         rd_valid,
  output logic [W-1:0] rd_data,
  output logic         full,
  output logic         empty
);

  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wp_q, rp_q, newest;
  logic [CNT_W-1:0] cnt_q;
  logic [W-1:0]     last_q;
  logic             do_pop, do_push, do_ovr;

  function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full    = (cnt_q == CNT_W'(DEPTH));
  assign empty   = (cnt_q == '0);
  assign do_pop  = pop_req && !empty;
  assign do_push = push_vld && (!full || do_pop);
  assign do_ovr  = push_vld && full && !do_pop;
  assign newest  = (wp_q == '0) ? PTR_W'(DEPTH - 1) : wp_q - 1'b1;

  always_ff @(posedge clk) begin
    if (do_push)     mem[wp_q]            <= push_word;
    else if (do_ovr) mem[newest][OVR_BIT] <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q   <= '0;
      rp_q   <= '0;
      cnt_q  <= '0;
      last_q <= '0;
    end else begin
      if (do_push) wp_q <= ptr_next(wp_q);
      if (do_pop) begin
        rp_q   <= ptr_next(rp_q);
        last_q <= mem[rp_q];
      end
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assign rd_valid = !empty;
  assign rd_data  = empty ? last_q : mem[rp_q];

endmodule

// File: rtl/uart_rx_break_top.sv
module uart_rx_break_top
  import uart_rx_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int OSR        = 16,
  parameter int FIFO_DEPTH = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              baud_tick,
  input  logic              rx_line,
  input  logic              par_en,
  input  logic              par_odd,
  input  logic              rd_ready,
  output logic              rd_valid,
  output logic [DATA_W+3:0] rd_data,
  output logic              fifo_empty,
  output logic              rx_irq
);

  localparam int WORD_W = DATA_W + FLAG_N;

  logic              line_s;
  logic              push_vld;
  logic [WORD_W-1:0] push_word;
  logic              fifo_full;

  uart_rx_sync #(
    .STAGES   (2),
    .RESET_VAL(1'b1)
  ) sync_i (
    .clk  (clk),
    .rst_n(rst_n),
    .d_in (rx_line),
    .d_out(line_s)
  );

  uart_rx_engine #(
    .DATA_W(DATA_W),
    .OSR   (OSR)
  ) engine_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .baud_tick(baud_tick),
    .line_s   (line_s),
    .par_en   (par_en),
    .par_odd  (par_odd),
    .push_vld (push_vld),
    .push_word(push_word)
  );

  uart_rx_tag_fifo #(
    .W      (WORD_W),
    .DEPTH  (FIFO_DEPTH),
    .OVR_BIT(DATA_W + FLAG_OE)
  ) fifo_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .push_vld (push_vld),
    .push_word(push_word),
    .pop_req  (rd_ready),
    .rd_valid (rd_valid),
    .rd_data  (rd_data),
    .full     (fifo_full),
    .empty    (fifo_empty)
  );

  assign rx_irq = rd_valid & (|rd_data[DATA_W+FLAG_BE:DATA_W+FLAG_FE]);

endmodule

// File: rtl/uart_rx_checker.sv
module uart_rx_checker
  import uart_rx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     par_en,
  input logic                     line_s,
  input logic                     push_vld,
  input logic [DATA_W+FLAG_N-1:0] push_word,
  input logic                     fifo_full,
  input logic                     rd_valid,
  input logic                     rd_ready,
  input logic [DATA_W+FLAG_N-1:0] rd_data,
  input logic                     rx_irq
);

  logic locked_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                    locked_q <= 1'b0;
    else if (push_vld && push_word[DATA_W+FLAG_BE]) locked_q <= 1'b1;
    else if (line_s)                               locked_q <= 1'b0;
  end

  p_break_word_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (push_vld && push_word[DATA_W+FLAG_BE]) |->
      (push_word[DATA_W-1:0] == '0 && !push_word[DATA_W+FLAG_FE] &&
       !push_word[DATA_W+FLAG_PE] && !push_word[DATA_W+FLAG_OE]));

  p_lockout_r7: assert property (@(posedge clk) disable iff (!rst_n)
    locked_q |-> !push_vld);

  p_no_parity_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (push_vld && !par_en) |-> !push_word[DATA_W+FLAG_PE]);

  p_overrun_full_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (push_vld && fifo_full && !rd_ready) |=> fifo_full);

  p_empty_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_valid |=> (rd_valid || $stable(rd_data)));

  p_irq_head_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rx_irq |-> (rd_valid && rd_data[DATA_W+FLAG_BE:DATA_W+FLAG_FE] != '0));

endmodule

bind uart_rx_break_top uart_rx_checker #(
  .DATA_W(DATA_W)
) chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .par_en   (par_en),
  .line_s   (line_s),
  .push_vld (push_vld),
  .push_word(push_word),
  .fifo_full(fifo_full),
  .rd_valid (rd_valid),
  .rd_ready (rd_ready),
  .rd_data  (rd_data),
  .rx_irq   (rx_irq)
);

// File: tb/uart_rx_break_top_tb_top.sv
`timescale 1ns/1ps
module uart_rx_break_top_tb_top;

  localparam int DATA_W   = 8;
  localparam int OSR      = 16;
  localparam int DEPTH    = 16;
  localparam int WORD_W   = DATA_W + 4;
  localparam int TICK_DIV = 2;
  localparam int BIT_CLK  = OSR * TICK_DIV;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              baud_tick = 1'b0;
  logic              rx_line = 1'b1;
  logic              par_en = 1'b0;
  logic              par_odd = 1'b0;
  logic              rd_ready = 1'b0;
  logic              rd_valid;
  logic [WORD_W-1:0] rd_data;
  logic              fifo_empty;
  logic              rx_irq;

  int n_checks = 0;
  int n_fail   = 0;
  int tcnt     = 0;
  logic [WORD_W-1:0] model_q[$];
  logic [WORD_W-1:0] last_pop = '0;

  always #5 clk = ~clk;

  always @(negedge clk) begin
    tcnt      = (tcnt + 1) % TICK_DIV;
    baud_tick = (tcnt == 0);
  end

  uart_rx_break_top #(
    .DATA_W    (DATA_W),
    .OSR       (OSR),
    .FIFO_DEPTH(DEPTH)
  ) dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .baud_tick (baud_tick),
    .rx_line   (rx_line),
    .par_en    (par_en),
    .par_odd   (par_odd),
    .rd_ready  (rd_ready),
    .rd_valid  (rd_valid),
    .rd_data   (rd_data),
    .fifo_empty(fifo_empty),
    .rx_irq    (rx_irq)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic string req_of(input logic [WORD_W-1:0] w);
    if (w[10])     return "R6";
    else if (w[11]) return "R9";
    else if (w[9])  return "R4";
    else if (w[8])  return "R3";
    else            return "R1";
  endfunction

  // Expected word of one character, computed from the requirements
  function automatic logic [WORD_W-1:0] exp_word(input logic [7:0] d, input bit pen,
                                                  input bit pbit, input bit odd, input bit stop);
    logic [WORD_W-1:0] w;
    if (d == 8'h00 && (!pen || !pbit) && !stop) begin
      w = 12'h400;
    end else begin
      w      = '0;
      w[7:0] = d;
      w[8]   = !stop;
      w[9]   = pen && (pbit != ((^d) ^ odd));
    end
    return w;
  endfunction

  task automatic model_push(input logic [WORD_W-1:0] w);
    if (model_q.size() < DEPTH) model_q.push_back(w);
    else model_q[model_q.size()-1][11] = 1'b1;
  endtask

  task automatic hold_line(input bit v, input int nbits);
    rx_line = v;
    repeat (nbits * BIT_CLK) @(negedge clk);
  endtask

  task automatic send_char(input logic [7:0] d, input bit pen, input bit odd,
                           input bit bad_par, input bit bad_stop);
    bit pbit;
    par_en  = pen;
    par_odd = odd;
    pbit    = (^d) ^ odd ^ bad_par;
    hold_line(1'b0, 1);
    for (int i = 0; i < DATA_W; i++) hold_line(d[i], 1);
    if (pen) hold_line(pbit, 1);
    hold_line(!bad_stop, 1);
    hold_line(1'b1, 2);
    model_push(exp_word(d, pen, pbit, odd, !bad_stop));
  endtask

  task automatic drain();
    logic [WORD_W-1:0] e;
    while (model_q.size() > 0) begin
      @(negedge clk);
      chk(rd_valid == 1'b1, "R8 word present", {31'd0, rd_valid}, 32'd1);
      if (!rd_valid) begin
        model_q.delete();
        break;
      end
      e = model_q.pop_front();
      chk(rd_data == e, req_of(e), {20'd0, rd_data}, {20'd0, e});
      chk(rx_irq == (|e[10:8]), "R11 irq", {31'd0, rx_irq}, {31'd0, |e[10:8]});
      rd_ready = 1'b1;
      @(negedge clk);
      rd_ready = 1'b0;
      last_pop = e;
    end
    @(negedge clk);
    chk(rd_valid == 1'b0, "R8 queue drained", {31'd0, rd_valid}, 32'd0);
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R12 reset state
    chk(rd_valid == 1'b0, "R12 rd_valid", {31'd0, rd_valid}, 32'd0);
    chk(fifo_empty == 1'b1, "R12 fifo_empty", {31'd0, fifo_empty}, 32'd1);
    chk(rx_irq == 1'b0, "R12 rx_irq", {31'd0, rx_irq}, 32'd0);
    chk(rd_data == '0, "R12 rd_data", {20'd0, rd_data}, 32'd0);
    hold_line(1'b1, 2);

    // R1 R4 R5: directed parity cases
    send_char(8'hA5, 1'b0, 1'b0, 1'b0, 1'b0);
    send_char(8'h37, 1'b1, 1'b0, 1'b0, 1'b0);
    send_char(8'h37, 1'b1, 1'b1, 1'b1, 1'b0);
    send_char(8'h01, 1'b1, 1'b1, 1'b0, 1'b0);
    drain();

    // R2: short low glitch leaves nothing
    rx_line = 1'b0;
    repeat (8) @(negedge clk);
    hold_line(1'b1, 3);
    chk(rd_valid == 1'b0, "R2 glitch rejected", {31'd0, rd_valid}, 32'd0);

    // R3 R8: random batches with corrupted parity and stop bits
    for (int b = 0; b < 12; b++) begin
      int n;
      n = 1 + int'($urandom_range(4, 0));
      for (int k = 0; k < n; k++) begin
        logic [7:0] d;
        d = ($urandom_range(7, 0) == 0) ? 8'h00 : 8'($urandom());
        send_char(d, 1'($urandom()), 1'($urandom()),
                  ($urandom_range(4, 0) == 0), ($urandom_range(5, 0) == 0));
      end
      drain();
    end

    // R6: long break gives one zero word; R7: still low means still locked
    par_en = 1'b0;
    hold_line(1'b0, 30);
    model_push(12'h400);
    drain();
    hold_line(1'b0, 20);
    chk(rd_valid == 1'b0, "R7 locked while low", {31'd0, rd_valid}, 32'd0);
    hold_line(1'b1, 2);
    send_char(8'h5A, 1'b0, 1'b0, 1'b0, 1'b0);
    drain();
    chk(last_pop == 12'h05A, "R7 char after mark and start", {20'd0, last_pop}, 32'h05A);

    // R6 with parity slot: break over 11 samples
    send_char(8'h00, 1'b1, 1'b0, 1'b0, 1'b1);
    drain();

    // R9: overrun by burst of DEPTH+2 characters
    for (int k = 0; k < DEPTH + 2; k++) begin
      send_char(8'(k + 1), 1'b0, 1'b0, 1'b0, 1'b0);
    end
    @(negedge clk);
    chk(model_q[DEPTH-1][11] == 1'b1, "R9 model tags newest", 32'd1, 32'd1);
    drain();

    // R10: pop while empty changes nothing
    rd_ready = 1'b1;
    repeat (3) @(negedge clk);
    rd_ready = 1'b0;
    @(negedge clk);
    chk(rd_data == last_pop, "R10 empty read holds word", {20'd0, rd_data}, {20'd0, last_pop});
    chk(rd_valid == 1'b0, "R10 still empty", {31'd0, rd_valid}, 32'd0);
    chk(fifo_empty == 1'b1, "R10 empty flag", {31'd0, fifo_empty}, 32'd1);
    chk(rx_irq == 1'b0, "R11 no irq when empty", {31'd0, rx_irq}, 32'd0);

    finish_run();
  end

endmodule